// File: doc/BRIEF.md
# Page Programming Status Tracker

This block follows the life of a page-programmed nonvolatile memory. It watches page-buffer load commands, write strobes, programming and erase requests and a brownout-detect input. From these it keeps a four-bit status byte and answers data-polling reads while a cycle runs.

The length of the programming cycle comes from an internal counter of `CYCLE_LEN` clocks, which stands in for the real timing generator. When no cycle is running, reads pass the memory array's data through unchanged. The array, the timing generator and the command decoder are outside the block.

The sequencer has three states:
- **IDLE**: no cycle is running.
- **PROG**: a page-programming cycle is running.
- **ERASE**: an erase cycle is running.

It has these transitions:
- **IDLE→PROG**: a start request arrives with the erase select low and no brownout.
- **IDLE→ERASE**: a start request arrives with the erase select high and no brownout.
- **PROG→IDLE** and **ERASE→IDLE**: taken at the clock edge after the counter reaches `CYCLE_LEN-1`.

In IDLE, a start request made during a brownout is dropped.

Top module: `pgm_status_tracker`

## Requirements
- R1: The status output places LOAD at bit 3, SUCCESS at bit 2, WRTINH at bit 1 and BUSY at bit 0. Bits 7..4 always read 0. After reset with no brownout, status reads 0Fh.
- R2: A load-page-buffer command clears LOAD at the next edge. A later write strobe with no load command in the same cycle sets LOAD at its edge. When both arrive in the same cycle, the load command wins.
- R3: A start request accepted in IDLE begins a cycle at the next edge. SUCCESS is cleared at that edge. BUSY then reads 0 for exactly `CYCLE_LEN` clocks.
- R4: When a cycle ends, SUCCESS is set to 1 only if `bod_low` was 0 on every sampled clock of the cycle, the final clock included. A brownout does not change the cycle length.
- R5: WRTINH equals the inverse of `bod_low`. BUSY reads 0 whenever `bod_low` is 1.
- R6: A start request made while `bod_low` is 1 is ignored. No cycle starts, and SUCCESS keeps its value.
- R7: During a PROG cycle, a read of the polled address returns the polled byte with bit 7 inverted. Read data appears one clock after the request.
- R8: The polled byte and polled address are those of the last write strobe accepted in IDLE before the start. This holds even when a higher address was written earlier.
- R9: During an ERASE cycle, every read returns 7Fh.
- R10: During a PROG cycle, a read of any address other than the polled one returns FFh.
- R11: In IDLE, a read returns `arr_data` one clock after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_cmd | input | 1 | Load-page-buffer command pulse |
| wr_stb | input | 1 | Memory write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data |
| prog_start | input | 1 | Request to start a cycle |
| erase_sel | input | 1 | Marks the requested cycle as an erase |
| bod_low | input | 1 | Brownout: supply is below the programming minimum |
| rd_req | input | 1 | Read request |
| rd_addr | input | AW | Read address |
| arr_data | input | 8 | Read data from the memory array |
| status | output | 8 | Status byte |
| rd_data | output | 8 | Registered read data |

## Verification
Two functions can fall in the same clock:
- the end of a cycle and a brownout sample;
- the end of a cycle and a polling read.

To provoke both, the bench raises `bod_low` and issues a read of the polled address in the final busy clock. It then expects the read to come back with bit 7 inverted, since the cycle was still running at that edge. It also expects SUCCESS to stay 0 and BUSY to return to 1 once the brownout is removed. Full sweeps of every address under PROG, ERASE and IDLE cover the remaining read paths.

// File: rtl/pst_pkg.sv
`timescale 1ns/1ps
package pst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_ERASE = 2'd2
    } cyc_state_t;

    localparam logic [7:0] POLL_ERASE = 8'h7F;
    localparam logic [7:0] POLL_OTHER = 8'hFF;
endpackage

// File: rtl/pst_cycle_fsm.sv
`timescale 1ns/1ps
module pst_cycle_fsm
    import pst_pkg::*;
#(
    parameter int CYCLE_LEN = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_start,
    input  logic erase_sel,
    input  logic bod_low,
    output logic running,
    output logic erasing,
    output logic cyc_begin,
    output logic cyc_end
);
    localparam int CW = $clog2(CYCLE_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLE_LEN - 1);

    cyc_state_t st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          begin_c, end_c;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        begin_c = 1'b0;
        end_c   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (prog_start && !bod_low) begin
                    begin_c = 1'b1;
                    cnt_d   = '0;
                    st_d    = erase_sel ? ST_ERASE : ST_PROG;
                end
            end
            ST_PROG, ST_ERASE: begin
                if (cnt_q == LAST) begin
                    end_c = 1'b1;
                    st_d  = ST_IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        running   = (st_q != ST_IDLE);
        erasing   = (st_q == ST_ERASE);
        cyc_begin = begin_c;
        cyc_end   = end_c;
    end
endmodule

// File: rtl/pst_flags.sv
`timescale 1ns/1ps
module pst_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_cmd,
    input  logic       wr_stb,
    input  logic       cyc_begin,
    input  logic       cyc_end,
    input  logic       running,
    input  logic       bod_low,
    output logic [7:0] status
);
    logic load_q, succ_q, seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= 1'b1;
            succ_q <= 1'b1;
            seen_q <= 1'b0;
        end else begin
            if (load_cmd)    load_q <= 1'b0;
            else if (wr_stb) load_q <= 1'b1;

            if (cyc_begin) begin
                succ_q <= 1'b0;
                seen_q <= 1'b0;
            end else if (running) begin
                seen_q <= seen_q | bod_low;
                if (cyc_end) succ_q <= !(seen_q | bod_low);
            end
        end
    end

    always_comb begin
        status    = 8'h00;
        status[3] = load_q;
        status[2] = succ_q;
        status[1] = !bod_low;
        status[0] = !(running | bod_low);
    end
endmodule

// File: rtl/pst_poll_path.sv
`timescale 1ns/1ps
module pst_poll_path
    import pst_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          running,
    input  logic          erasing,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    input  logic [7:0]    arr_data,
    output logic [AW-1:0] poll_addr,
    output logic [7:0]    rd_data
);
    logic [7:0]    poll_q;
    logic [AW-1:0] paddr_q;
    logic [7:0]    rd_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poll_q  <= 8'hFF;
            paddr_q <= '0;
        end else if (wr_stb && !running) begin
            poll_q  <= wr_data;
            paddr_q <= wr_addr;
        end
    end

    always_comb begin
        if (erasing)
            rd_c = POLL_ERASE;
        else if (running)
            rd_c = (rd_addr == paddr_q) ? {~poll_q[7], poll_q[6:0]} : POLL_OTHER;
        else
            rd_c = arr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_data <= 8'hFF;
        else if (rd_req) rd_data <= rd_c;
    end

    assign poll_addr = paddr_q;
endmodule

// File: rtl/pgm_status_tracker.sv
`timescale 1ns/1ps
module pgm_status_tracker #(
    parameter int AW        = 8,
    parameter int CYCLE_LEN = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_cmd,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          prog_start,
    input  logic          erase_sel,
    input  logic          bod_low,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    input  logic [7:0]    arr_data,
    output logic [7:0]    status,
    output logic [7:0]    rd_data
);
    logic          running, erasing, cyc_begin, cyc_end;
    logic [AW-1:0] poll_addr;

    pst_cycle_fsm #(.CYCLE_LEN(CYCLE_LEN)) u_fsm (
        .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .erase_sel(erase_sel),
        .bod_low(bod_low), .running(running), .erasing(erasing),
        .cyc_begin(cyc_begin), .cyc_end(cyc_end)
    );

    pst_flags u_flags (
        .clk(clk), .rst_n(rst_n), .load_cmd(load_cmd), .wr_stb(wr_stb),
        .cyc_begin(cyc_begin), .cyc_end(cyc_end), .running(running),
        .bod_low(bod_low), .status(status)
    );

    pst_poll_path #(.AW(AW)) u_poll (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .running(running), .erasing(erasing),
        .rd_req(rd_req), .rd_addr(rd_addr), .arr_data(arr_data),
        .poll_addr(poll_addr), .rd_data(rd_data)
    );
endmodule

// File: rtl/pst_checker.sv
`timescale 1ns/1ps
module pst_checker #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          load_cmd,
    input logic          wr_stb,
    input logic          prog_start,
    input logic          bod_low,
    input logic          rd_req,
    input logic [AW-1:0] rd_addr,
    input logic [7:0]    status,
    input logic [7:0]    rd_data,
    input logic          running,
    input logic          erasing,
    input logic [AW-1:0] poll_addr
);
    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        status[7:4] == 4'h0);

    assert_load_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_cmd |=> !status[3]);

    assert_load_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !load_cmd) |=> status[3]);

    assert_success_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> (!status[2] && !status[0]));

    assert_busy_bod_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bod_low |-> !status[0]);

    assert_start_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && bod_low && prog_start) |=> !running);

    assert_erase_poll_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && erasing) |=> (rd_data == 8'h7F));

    assert_other_ff_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && running && !erasing && rd_addr != poll_addr) |=> (rd_data == 8'hFF));
endmodule

bind pgm_status_tracker pst_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .load_cmd(load_cmd), .wr_stb(wr_stb),
    .prog_start(prog_start), .bod_low(bod_low), .rd_req(rd_req),
    .rd_addr(rd_addr), .status(status), .rd_data(rd_data),
    .running(running), .erasing(erasing), .poll_addr(poll_addr)
);

// File: tb/sim_pgm_status_tracker.sv
`timescale 1ns/1ps
module sim_pgm_status_tracker;
    localparam int AW = 4;
    localparam int L  = 20;
    localparam int NA = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_cmd = 1'b0, wr_stb = 1'b0, prog_start = 1'b0;
    logic          erase_sel = 1'b0, bod_low = 1'b0, rd_req = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    arr_data;
    logic [7:0]    status, rd_data;

    int checks = 0, errors = 0, busy_cnt = 0;
    logic [7:0]    poll_v;
    logic [AW-1:0] poll_a;

    always #2 clk = ~clk;
    assign arr_data = {4'h0, rd_addr} ^ 8'hA5;

    pgm_status_tracker #(.AW(AW), .CYCLE_LEN(L)) u0 (
        .clk(clk), .rst_n(rst_n), .load_cmd(load_cmd), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .prog_start(prog_start),
        .erase_sel(erase_sel), .bod_low(bod_low), .rd_req(rd_req),
        .rd_addr(rd_addr), .arr_data(arr_data), .status(status), .rd_data(rd_data)
    );

    always @(negedge clk) if (rst_n && !status[0]) busy_cnt++;

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write(input logic [AW-1:0] a, input logic [7:0] d);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_stb = 1'b0;
        poll_a = a; poll_v = d;
    endtask

    task automatic start(input logic er);
        busy_cnt = 0;
        prog_start = 1'b1; erase_sel = er;
        step();
        prog_start = 1'b0; erase_sel = 1'b0;
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 200 && status[0] == 1'b0; g++) step();
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 reset status", status, 8'h0F);

        // brownout in idle
        bod_low = 1'b1;
        step();
        chk("R5 bod status", status, 8'h0C);
        prog_start = 1'b1;
        step();
        prog_start = 1'b0; bod_low = 1'b0;
        step();
        chk("R6 start ignored", status, 8'h0F);
        step();
        chk("R6 still idle", status, 8'h0F);

        // LOAD flag
        load_cmd = 1'b1;
        step();
        load_cmd = 1'b0;
        chk("R2 load cleared", status[3], 1'b0);
        step();
        chk("R2 load holds", status[3], 1'b0);

        // page fill: every address, then a last lower address
        for (int a = 0; a < NA; a++) begin
            write(a[AW-1:0], 8'((a * 37 + 11) & 8'hFF));
            if (a == 0) chk("R2 load set by write", status[3], 1'b1);
        end
        write(4'd6, 8'hC3);

        // programming cycle with full read sweep
        start(1'b0);
        chk("R3 busy and success cleared", status, 8'h0A);
        for (int a = 0; a < NA; a++) begin
            rd_req = 1'b1; rd_addr = a[AW-1:0];
            step();
            if (a[AW-1:0] == poll_a)
                chk("R7 R8 polled byte", rd_data, {~poll_v[7], poll_v[6:0]});
            else
                chk("R10 other address", rd_data, 8'hFF);
        end
        rd_req = 1'b0;
        wait_idle();
        chk("R3 cycle length", busy_cnt, L);
        chk("R4 success after clean cycle", status, 8'h0F);

        // idle reads sweep
        for (int a = 0; a < NA; a++) begin
            rd_req = 1'b1; rd_addr = a[AW-1:0];
            step();
            chk("R11 idle read", rd_data, {4'h0, a[AW-1:0]} ^ 8'hA5);
        end
        rd_req = 1'b0;

        // erase cycle
        start(1'b1);
        for (int a = 0; a < NA; a++) begin
            rd_req = 1'b1; rd_addr = a[AW-1:0];
            step();
            chk("R9 erase poll", rd_data, 8'h7F);
        end
        rd_req = 1'b0;
        wait_idle();
        chk("R3 erase length", busy_cnt, L);
        chk("R4 erase success", status[2], 1'b1);

        // brownout in the middle of a cycle
        write(4'd2, 8'h11);
        start(1'b0);
        repeat (3) step();
        bod_low = 1'b1;
        step();
        chk("R5 wrtinh low in cycle", status[1:0], 2'b00);
        bod_low = 1'b0;
        wait_idle();
        chk("R4 length kept", busy_cnt, L);
        chk("R4 success low after bod", status, 8'h0B);

        // clean cycle restores success
        start(1'b0);
        wait_idle();
        chk("R4 success restored", status, 8'h0F);

        // brownout and poll read in the final busy clock
        start(1'b0);
        repeat (L - 1) step();
        chk("R3 still busy at last clock", status[0], 1'b0);
        bod_low = 1'b1; rd_req = 1'b1; rd_addr = poll_a;
        step();
        chk("R7 read at final edge", rd_data, {~poll_v[7], poll_v[6:0]});
        bod_low = 1'b0; rd_req = 1'b0;
        #0;
        chk("R4 bod at final clock", status, 8'h0B);
        step();
        chk("R3 ended on time", status, 8'h0B);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule